// File: doc/BRIEF.md
# Programmable-Tap Gold Code Generator

This block produces a pseudo-random chip stream by combining two 10-bit linear feedback shift registers. Which bit positions feed each register's feedback, and which positions of the second register enter the output mix, are not fixed constants. They come from two tap-select bytes held elsewhere in the chip and presented to the block as plain inputs.

A sync input reloads both shift registers with all ones and silences the output. Each single-cycle step pulse advances both registers by one chip. The output bit is the most significant bit of the first register XORed with a two-bit XOR taken from the second register. It passes through a staging register and then an output register, so it lags the register state by two clock edges.

Top module: `gold_code_gen`

## Requirements
- R1: While `sync` is high (and while `rst` is high), both shift registers are loaded with all ones, and the staging and output registers are cleared. So `chip_o` is 0 after any edge at which sync or reset was high.
- R2: On an edge where `step` is high and `sync` is low, the first register shifts left by one. Its new bit 0 is the XOR of its bits at the indices `fb_sel_a[3:0]` and `fb_sel_a[7:4]`.
- R3: On the same kind of edge, the second register shifts left by one. Its new bit 0 is the XOR of its bits at the indices `fb_sel_b[3:0]` and `fb_sel_b[7:4]`.
- R4: On an edge where `step` and `sync` are both low, both registers keep their value.
- R5: On each edge with `sync` low, the staging register takes bit 9 of the first register and the XOR of the second register's bits at the `fb_sel_b` indices. On the next edge, `chip_o` takes the XOR of the two staged bits.
- R6: A tap index of 10 or above selects a constant 0 in place of a register bit.
- R7: When `sync` and `step` are high together, sync wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Reload both registers to all ones |
| step | input | 1 | Chip advance pulse |
| fb_sel_a | input | 8 | Two 4-bit feedback tap indices for the first register |
| fb_sel_b | input | 8 | Two 4-bit tap indices for the second register |
| chip_o | output | 1 | Registered code bit |

## Verification
The bench uses the default widths: 10-bit registers and 4-bit tap indices. With a 4-bit index, the values 10 to 15 can be written, so the constant-zero selection of R6 can be reached. With 10-bit registers, a full sequence period of 1023 chips fits well inside the run. The bench runs more than that many chips with irregular step gaps, several tap choices, a sync that collides with a step, and tap changes in the middle of a run. It compares every output cycle against an independent model.

// File: rtl/gold_code_pkg.sv
package gold_code_pkg;
    localparam int unsigned GC_REG_W = 10;
    localparam int unsigned GC_IDX_W = 4;

    typedef struct packed {
        logic lead;   // top bit of first register
        logic mix;    // tapped XOR of second register
    } gc_stage_t;
endpackage

// File: rtl/gc_lfsr.sv
module gc_lfsr #(
    parameter int unsigned REG_W = gold_code_pkg::GC_REG_W,
    parameter int unsigned IDX_W = gold_code_pkg::GC_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync,
    input  logic               step,
    input  logic [2*IDX_W-1:0] tap_sel,
    output logic [REG_W-1:0]   state_o,
    output logic               tap_xor_o
);
    logic [REG_W-1:0] state_q;
    logic [IDX_W-1:0] idx_lo, idx_hi;

    assign idx_lo = tap_sel[IDX_W-1:0];
    assign idx_hi = tap_sel[2*IDX_W-1:IDX_W];

    function automatic logic bit_at(input logic [REG_W-1:0] v, input logic [IDX_W-1:0] i);
        logic r;
        r = 1'b0;
        for (int k = 0; k < int'(REG_W); k++) begin
            if (i == IDX_W'(k)) r = v[k];
        end
        return r;
    endfunction

    assign tap_xor_o = bit_at(state_q, idx_lo) ^ bit_at(state_q, idx_hi);

    always_ff @(posedge clk) begin
        if (rst || sync) begin
            state_q <= '1;
        end else if (step) begin
            state_q <= {state_q[REG_W-2:0], tap_xor_o};
        end
    end

    assign state_o = state_q;

    // R1: reload to all ones
    p_sync_ones_r1: assert property (@(posedge clk) disable iff (rst)
        sync |=> state_q == {REG_W{1'b1}});
    // R4: idle holds state
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!sync && !step) |=> $stable(state_q));
    // R2 / R3: body of register moves up one place
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (!sync && step) |=> state_q[REG_W-1:1] == $past(state_q[REG_W-2:0]));
endmodule

// File: rtl/gc_combine.sv
module gc_combine
    import gold_code_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync,
    input  logic lead_i,
    input  logic mix_i,
    output logic chip_o
);
    gc_stage_t stage_q;
    logic      chip_q;

    always_ff @(posedge clk) begin
        if (rst || sync) begin
            stage_q <= '0;
            chip_q  <= 1'b0;
        end else begin
            stage_q.lead <= lead_i;
            stage_q.mix  <= mix_i;
            chip_q       <= stage_q.lead ^ stage_q.mix;
        end
    end

    assign chip_o = chip_q;

    // R1: output silenced by sync
    p_sync_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        sync |=> !chip_q);
    // R5: staged bits follow the inputs one edge later
    p_stage_lead_r5: assert property (@(posedge clk) disable iff (rst)
        !sync |=> stage_q.lead == $past(lead_i));
endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen #(
    parameter int unsigned REG_W = gold_code_pkg::GC_REG_W,
    parameter int unsigned IDX_W = gold_code_pkg::GC_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync,
    input  logic               step,
    input  logic [2*IDX_W-1:0] fb_sel_a,
    input  logic [2*IDX_W-1:0] fb_sel_b,
    output logic               chip_o
);
    logic [REG_W-1:0] state_a, state_b;
    logic             xor_a, xor_b;

    gc_lfsr #(.REG_W(REG_W), .IDX_W(IDX_W)) u_reg_a (
        .clk(clk), .rst(rst), .sync(sync), .step(step),
        .tap_sel(fb_sel_a), .state_o(state_a), .tap_xor_o(xor_a)
    );

    gc_lfsr #(.REG_W(REG_W), .IDX_W(IDX_W)) u_reg_b (
        .clk(clk), .rst(rst), .sync(sync), .step(step),
        .tap_sel(fb_sel_b), .state_o(state_b), .tap_xor_o(xor_b)
    );

    gc_combine u_comb (
        .clk(clk), .rst(rst), .sync(sync),
        .lead_i(state_a[REG_W-1]), .mix_i(xor_b), .chip_o(chip_o)
    );

    // R7: sync beats step, both registers end at all ones
    p_sync_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (sync && step) |=> (state_a == {REG_W{1'b1}}) && (state_b == {REG_W{1'b1}}));

    logic unused_ok;
    assign unused_ok = ^{xor_a, state_b};
endmodule

// File: tb/tb_gold_code_gen.sv
module tb_gold_code_gen;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst, sync, step;
    logic [7:0] fb_sel_a, fb_sel_b;
    logic chip_o;

    always #2 clk = ~clk;   // 250 MHz

    gold_code_gen dut (
        .clk(clk), .rst(rst), .sync(sync), .step(step),
        .fb_sel_a(fb_sel_a), .fb_sel_b(fb_sel_b), .chip_o(chip_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic  exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";

    // independent model
    logic [W-1:0] m_a, m_b;
    logic m_lead, m_mix, m_chip;

    function automatic logic sel_bit(input logic [W-1:0] v, input logic [3:0] i);
        if (i >= 4'd10) return 1'b0;   // R6
        return v[i];
    endfunction

    task automatic model_clear();
        m_a = '1; m_b = '1; m_lead = 0; m_mix = 0; m_chip = 0;
    endtask

    task automatic drive(input logic s, input logic st, input logic [7:0] sa, input logic [7:0] sb);
        logic fa, fb;
        @(negedge clk);
        sync = s; step = st; fb_sel_a = sa; fb_sel_b = sb;
        if (s) begin
            model_clear();
        end else begin
            fa = sel_bit(m_a, sa[3:0]) ^ sel_bit(m_a, sa[7:4]);
            fb = sel_bit(m_b, sb[3:0]) ^ sel_bit(m_b, sb[7:4]);
            m_chip = m_lead ^ m_mix;
            m_lead = m_a[W-1];
            m_mix  = fb;
            if (st) begin
                m_a = {m_a[W-2:0], fa};
                m_b = {m_b[W-2:0], fb};
            end
        end
        exp_q.push_back(m_chip);
        tag_q.push_back(cur_tag);
    endtask

    // monitor: compare one item per edge, 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (chip_o !== e) begin
                    n_fail++;
                    $display("FAIL %s: chip_o=%b expected %b at %0t", t, chip_o, e, $time);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; sync = 0; step = 0; fb_sel_a = 8'h92; fb_sel_b = 8'h62;
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (chip_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset chip_o=%b expected 0", chip_o);
        end
        @(negedge clk); rst = 0;

        // R1: sync held several cycles
        cur_tag = "R1";
        for (int i = 0; i < 4; i++) drive(1, 0, 8'h92, 8'h62);

        // R2 R3 R5: continuous stepping, a full period and more
        cur_tag = "R2_R3_R5";
        for (int i = 0; i < 1100; i++) drive(0, 1, 8'h92, 8'h62);

        // R4: irregular gaps between steps
        cur_tag = "R4";
        for (int i = 0; i < 300; i++) drive(0, (i % 3) != 0, 8'h92, 8'h62);

        // R7: sync together with step
        cur_tag = "R7";
        drive(1, 1, 8'h92, 8'h62);
        for (int i = 0; i < 40; i++) drive(0, 1, 8'h92, 8'h62);

        // R3: other taps on the second register, changed mid-run
        cur_tag = "R3";
        for (int i = 0; i < 200; i++) drive(0, 1, 8'h92, 8'h81);
        for (int i = 0; i < 200; i++) drive(0, (i % 2) == 0, 8'h73, 8'h95);

        // R6: indices of 10 and above read as zero
        cur_tag = "R6";
        drive(1, 0, 8'hC9, 8'hF1);
        for (int i = 0; i < 150; i++) drive(0, 1, 8'hC9, 8'hF1);
        for (int i = 0; i < 100; i++) drive(0, 1, 8'h9A, 8'hBE);

        // R1: sync after a long run
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) drive(1, i == 1, 8'h92, 8'h62);
        cur_tag = "R5";
        for (int i = 0; i < 20; i++) drive(0, 1, 8'h92, 8'h62);

        drive(0, 0, 8'h92, 8'h62);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule